// File: doc/BRIEF.md
# Exception Entry Sequencer with Mode-Banked Shadow Registers

This block performs the entry half of processor exception handling. A one-cycle request arrives with a cause code: privileged call, instruction trap, data trap or interrupt. In the next clock edge the block picks the target processor mode and forms the vector address. Normal vectors sit near address zero. When the high-vector control bit is set, the vectors move to the top 64 KiB. The block then emits a one-cycle redirect strobe that carries the new program counter and the new status word.

The block owns the live copies of the stack register (r29), the link register (r30) and the saved-status register. It also holds one shadow bank of those three registers for each mode group. On a mode change it saves the live triple into the outgoing mode's bank and brings back r29 from the incoming mode's bank. The entry itself then overwrites r30 with the faulting PC and the saved-status register with the old status word. The rest of the core writes the live registers through a simple write port. A read-only debug port exposes every bank and the live triple.

The request is a plain strobe, not a stream. There is no ready signal and no back-pressure. A request is taken on the clock edge where it is high. An illegal cause or an illegal current mode raises an error pulse instead of an entry.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, redirect and error are low, the new PC and new status outputs are zero, and every banked and live register reads zero.
- R2: Modes are coded in status bits [4:0] as user 0x10, interrupt 0x12, privileged 0x13, trap 0x17, extension 0x1B and supervisor-user 0x1F. User and supervisor-user share bank 0. Privileged uses bank 1, trap bank 2, extension bank 3 and interrupt bank 4.
- R3: On an entry that changes the mode, the pre-entry live r29, r30 and saved-status values are written into the outgoing mode's bank. No other bank changes.
- R4: On an entry that changes the mode, live r29 takes the value held in the incoming mode's bank.
- R5: On an entry whose target mode equals the current mode, no bank is written and live r29 keeps its value.
- R6: Cause codes are 0 privileged call, 1 instruction trap, 2 data trap and 3 interrupt. They enter privileged mode at 0x08, trap mode at 0x0C, trap mode at 0x10 and interrupt mode at 0x18 respectively.
- R7: With the high-vector bit set at the request, 0xFFFF0000 is added to the vector offset.
- R8: The new status equals the request's status word with bits [4:0] replaced by the target mode and bit 7 (interrupt disable) set. The live saved-status register takes the request's status word.
- R9: Live r30 and the link output take the request's PC.
- R10: Redirect is high for exactly the cycle after an accepted request. The new PC and new status outputs hold their values until the next entry.
- R11: A cause code of 4 to 7, or a current mode outside the R2 list, gives a one-cycle error pulse in the cycle after the request. There is no redirect, and no output or register changes.
- R12: The write port selects with codes 0 for r29, 1 for r30 and 2 for saved status, and updates the live register on the next edge. An entry in the same cycle takes priority over the write port. The debug port selects bank 0 to 4, or 5 for the live triple, and uses the same field codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | One-cycle exception request |
| exc_cause | input | 3 | Cause code |
| cur_pc | input | 32 | PC of the interrupted instruction stream |
| cur_status | input | 32 | Current status word; bits [4:0] hold the mode |
| hivec_en | input | 1 | High-vector control bit |
| reg_we | input | 1 | Live register write enable |
| reg_sel | input | 2 | Live register select |
| reg_wdata | input | 32 | Live register write data |
| dbg_bank | input | 3 | Debug bank select (5 = live) |
| dbg_field | input | 2 | Debug field select |
| dbg_data | output | 32 | Debug read data |
| redirect | output | 1 | PC redirect strobe |
| new_pc | output | 32 | Vector address |
| new_status | output | 32 | Updated status word |
| link | output | 32 | Live r30 (link) value |
| err | output | 1 | Illegal cause or mode pulse |

## Verification
The assertions assume a request never lasts more than one cycle. They also assume the status word at a request carries a mode from the R2 list, or else the error path is taken. The assertions relate the redirect and error pulses to the inputs that were present one cycle earlier. The directed tasks raise exc_valid for a single cycle with inputs changed on the falling edge, and leave idle cycles between requests. Illegal modes and causes appear only in the tasks that target the error path. The bench keeps its own model of the five banks and the live triple, and compares every entry against all of it through the debug port.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MODE_W  = 5;
  localparam int CAUSE_W = 3;
  localparam int IDIS_BIT = 7;

  localparam logic [MODE_W-1:0] MODE_USER = 5'h10;
  localparam logic [MODE_W-1:0] MODE_INTR = 5'h12;
  localparam logic [MODE_W-1:0] MODE_PRIV = 5'h13;
  localparam logic [MODE_W-1:0] MODE_TRAP = 5'h17;
  localparam logic [MODE_W-1:0] MODE_EXTN = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SUSR = 5'h1F;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_PCALL = 3'd0,
    CAUSE_ITRAP = 3'd1,
    CAUSE_DTRAP = 3'd2,
    CAUSE_IRQ   = 3'd3
  } cause_e;

  typedef enum logic [1:0] {
    FLD_SP  = 2'd0,
    FLD_LR  = 2'd1,
    FLD_SSR = 2'd2
  } field_e;
endpackage

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic [exc_pkg::CAUSE_W-1:0] cause,
  input  logic                        hivec,
  output logic [exc_pkg::MODE_W-1:0]  tgt_mode,
  output logic [XLEN-1:0]             vec_addr,
  output logic                        cause_ok
);
  import exc_pkg::*;
  logic [7:0] offs;

  always_comb begin
    cause_ok = 1'b1;
    tgt_mode = MODE_PRIV;
    offs     = 8'h00;
    case (cause)
      CAUSE_PCALL: begin tgt_mode = MODE_PRIV; offs = 8'h08; end
      CAUSE_ITRAP: begin tgt_mode = MODE_TRAP; offs = 8'h0C; end
      CAUSE_DTRAP: begin tgt_mode = MODE_TRAP; offs = 8'h10; end
      CAUSE_IRQ:   begin tgt_mode = MODE_INTR; offs = 8'h18; end
      default:     cause_ok = 1'b0;
    endcase
    vec_addr = (hivec ? HIGH_BASE : '0) + XLEN'(offs);
  end
endmodule

// File: rtl/exc_bank_map.sv
module exc_bank_map #(
  parameter int IDX_W = 3
) (
  input  logic [exc_pkg::MODE_W-1:0] mode,
  output logic [IDX_W-1:0]           idx,
  output logic                       mode_ok
);
  import exc_pkg::*;
  always_comb begin
    mode_ok = 1'b1;
    idx     = '0;
    case (mode)
      MODE_USER, MODE_SUSR: idx = IDX_W'(0);
      MODE_PRIV:            idx = IDX_W'(1);
      MODE_TRAP:            idx = IDX_W'(2);
      MODE_EXTN:            idx = IDX_W'(3);
      MODE_INTR:            idx = IDX_W'(4);
      default:              mode_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/exc_bank_store.sv
module exc_bank_store #(
  parameter int XLEN      = 32,
  parameter int NUM_BANKS = 5,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_en,
  input  logic             swap_en,
  input  logic [IDX_W-1:0] old_idx,
  input  logic [IDX_W-1:0] new_idx,
  input  logic [XLEN-1:0]  link_val,
  input  logic [XLEN-1:0]  ssr_val,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_bank,
  input  logic [1:0]       rd_field,
  output logic [XLEN-1:0]  rd_data,
  output logic [XLEN-1:0]  live_lr
);
  import exc_pkg::*;
  localparam int LIVE_IDX = NUM_BANKS;

  logic [2:0][XLEN-1:0] bank_q [NUM_BANKS];
  logic [2:0][XLEN-1:0] live_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[b] <= '0;
      else if (entry_en && swap_en && old_idx == IDX_W'(b))
        bank_q[b] <= live_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (entry_en) begin
      if (swap_en && int'(new_idx) < NUM_BANKS)
        live_q[FLD_SP] <= bank_q[new_idx][FLD_SP];
      live_q[FLD_LR]  <= link_val;
      live_q[FLD_SSR] <= ssr_val;
    end else if (wr_en && wr_sel != 2'd3) begin
      live_q[wr_sel] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_field != 2'd3) begin
      if (int'(rd_bank) == LIVE_IDX)
        rd_data = live_q[rd_field];
      else if (int'(rd_bank) < NUM_BANKS)
        rd_data = bank_q[rd_bank][rd_field];
    end
  end

  assign live_lr = live_q[FLD_LR];

  assert_live_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    entry_en |=> live_q[FLD_LR] == $past(link_val));
  assert_ssr_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    entry_en |=> live_q[FLD_SSR] == $past(ssr_val));
  assert_same_mode_sp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_en && !swap_en) |=> $stable(live_q[FLD_SP]));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int XLEN = 32,
  parameter int NUM_BANKS = 5,
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_valid,
  input  logic [2:0]  exc_cause,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_status,
  input  logic        hivec_en,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [XLEN-1:0] reg_wdata,
  input  logic [2:0]  dbg_bank,
  input  logic [1:0]  dbg_field,
  output logic [XLEN-1:0] dbg_data,
  output logic        redirect,
  output logic [XLEN-1:0] new_pc,
  output logic [XLEN-1:0] new_status,
  output logic [XLEN-1:0] link,
  output logic        err
);
  import exc_pkg::*;
  localparam int IDX_W = $clog2(NUM_BANKS + 1);

  logic [MODE_W-1:0] cur_mode, tgt_mode;
  logic [XLEN-1:0]   vec_addr;
  logic              cause_ok, mode_ok, tgt_ok, accept, swap;
  logic [IDX_W-1:0]  old_idx, new_idx;

  assign cur_mode = cur_status[MODE_W-1:0];

  exc_vector_gen #(.XLEN(XLEN), .HIGH_BASE(HIGH_BASE)) u_vec (
    .cause(exc_cause), .hivec(hivec_en), .tgt_mode(tgt_mode),
    .vec_addr(vec_addr), .cause_ok(cause_ok));

  exc_bank_map #(.IDX_W(IDX_W)) u_map_old (
    .mode(cur_mode), .idx(old_idx), .mode_ok(mode_ok));

  exc_bank_map #(.IDX_W(IDX_W)) u_map_new (
    .mode(tgt_mode), .idx(new_idx), .mode_ok(tgt_ok));

  assign accept = exc_valid && cause_ok && mode_ok && tgt_ok;
  assign swap   = (cur_mode != tgt_mode);

  exc_bank_store #(.XLEN(XLEN), .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .entry_en(accept), .swap_en(swap),
    .old_idx(old_idx), .new_idx(new_idx), .link_val(cur_pc),
    .ssr_val(cur_status), .wr_en(reg_we), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .rd_bank(IDX_W'(dbg_bank)), .rd_field(dbg_field),
    .rd_data(dbg_data), .live_lr(link));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect   <= 1'b0;
      err        <= 1'b0;
      new_pc     <= '0;
      new_status <= '0;
    end else begin
      redirect <= accept;
      err      <= exc_valid && !accept;
      if (accept) begin
        new_pc <= vec_addr;
        new_status <= cur_status;
        new_status[IDIS_BIT] <= 1'b1;
        new_status[MODE_W-1:0] <= tgt_mode;
      end
    end
  end

  assert_redirect_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> $past(exc_valid));
  assert_err_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect && err));
  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(new_pc) && $stable(new_status)));
  assert_idis_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> new_status[IDIS_BIT]);
  assert_hivec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && $past(hivec_en)) |-> new_pc[XLEN-1:16] == HIGH_BASE[XLEN-1:16]);
  assert_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> link == $past(cur_pc));
endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
  logic clk = 0, rst_n = 0;
  logic exc_valid = 0, hivec_en = 0, reg_we = 0;
  logic [2:0] exc_cause = 0, dbg_bank = 0;
  logic [1:0] reg_sel = 0, dbg_field = 0;
  logic [31:0] cur_pc = 0, cur_status = 0, reg_wdata = 0;
  logic [31:0] dbg_data, new_pc, new_status, link;
  logic redirect, err;

  int total = 0, bad = 0;
  logic [31:0] mb [0:5][0:2];
  logic [31:0] m_pc, m_st;

  always #2.5 clk = ~clk;

  exc_entry_seq u_dut (.clk(clk), .rst_n(rst_n), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .cur_pc(cur_pc), .cur_status(cur_status),
    .hivec_en(hivec_en), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dbg_bank(dbg_bank), .dbg_field(dbg_field),
    .dbg_data(dbg_data), .redirect(redirect), .new_pc(new_pc),
    .new_status(new_status), .link(link), .err(err));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic check_store(input string tag);
    for (int b = 0; b < 6; b++)
      for (int f = 0; f < 3; f++) begin
        dbg_bank = 3'(b); dbg_field = 2'(f);
        #0.1;
        chk(dbg_data === mb[b][f], tag, dbg_data, mb[b][f]);
      end
  endtask

  task automatic wr_live(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    mb[5][sel] = d;
  endtask

  // Accepted entry; model from R2-R10
  task automatic entry(input logic [2:0] c, input logic [31:0] pc,
                       input logic [31:0] st, input bit hv, input string tag);
    logic [4:0] tm; logic [31:0] off, exp_st; int ob, nb;
    case (c)
      3'd0: begin tm = 5'h13; off = 32'h08; end
      3'd1: begin tm = 5'h17; off = 32'h0C; end
      3'd2: begin tm = 5'h17; off = 32'h10; end
      default: begin tm = 5'h12; off = 32'h18; end
    endcase
    if (hv) off = off + 32'hFFFF0000;
    exp_st = {st[31:8], 1'b1, st[6:5], tm};
    ob = bank_of(st[4:0]); nb = bank_of(tm);
    @(negedge clk);
    exc_valid = 1; exc_cause = c; cur_pc = pc; cur_status = st; hivec_en = hv;
    @(negedge clk);
    exc_valid = 0;
    if (st[4:0] != tm) begin
      for (int f = 0; f < 3; f++) mb[ob][f] = mb[5][f];
      mb[5][0] = mb[nb][0];
    end
    mb[5][1] = pc; mb[5][2] = st;
    m_pc = off; m_st = exp_st;
    chk(redirect === 1'b1, {tag, " R10 redirect"}, 32'(redirect), 1);
    chk(err === 1'b0, {tag, " R11 no err"}, 32'(err), 0);
    chk(new_pc === off, {tag, " R6/R7 vector"}, new_pc, off);
    chk(new_status === exp_st, {tag, " R8 status"}, new_status, exp_st);
    chk(link === pc, {tag, " R9 link"}, link, pc);
    @(negedge clk);
    chk(redirect === 1'b0, {tag, " R10 pulse end"}, 32'(redirect), 0);
    chk(new_pc === off, {tag, " R10 pc held"}, new_pc, off);
    check_store({tag, " R3/R4/R5 store"});
  endtask

  task automatic bad_req(input logic [2:0] c, input logic [31:0] st, input string tag);
    @(negedge clk);
    exc_valid = 1; exc_cause = c; cur_pc = 32'hDEAD0000; cur_status = st; hivec_en = 1;
    @(negedge clk);
    exc_valid = 0;
    chk(err === 1'b1, {tag, " R11 err"}, 32'(err), 1);
    chk(redirect === 1'b0, {tag, " R11 no redirect"}, 32'(redirect), 0);
    chk(new_pc === m_pc, {tag, " R11 pc kept"}, new_pc, m_pc);
    chk(new_status === m_st, {tag, " R11 status kept"}, new_status, m_st);
    @(negedge clk);
    chk(err === 1'b0, {tag, " R11 pulse end"}, 32'(err), 0);
    check_store({tag, " R11 store kept"});
  endtask

  task automatic t_reset();
    chk(redirect === 0 && err === 0, "R1 strobes", {30'b0, redirect, err}, 0);
    chk(new_pc === 0, "R1 new_pc", new_pc, 0);
    chk(new_status === 0, "R1 new_status", new_status, 0);
    check_store("R1 store");
  endtask

  task automatic t_write_port();
    wr_live(2'd0, 32'hA0A0_0029);
    wr_live(2'd1, 32'hA0A0_0030);
    wr_live(2'd2, 32'hA0A0_00F0);
    check_store("R12 write port");
  endtask

  task automatic t_chain();
    entry(3'd0, 32'h0000_0100, 32'h1234_5610, 0, "R2 user->priv");
    wr_live(2'd0, 32'hB1B1_0029);
    entry(3'd3, 32'h0000_0200, 32'h0000_0013, 0, "R3 priv->intr");
    wr_live(2'd0, 32'hC4C4_0029);
    entry(3'd1, 32'h0000_0300, 32'h0000_0092, 0, "R3 intr->trap itrap");
    entry(3'd0, 32'h0000_0400, 32'h0000_0017, 0, "R4 trap->priv restore");
    chk(mb[5][0] === 32'hB1B1_0029, "R4 sp restored model", mb[5][0], 32'hB1B1_0029);
  endtask

  task automatic t_same_mode();
    wr_live(2'd0, 32'h5555_0029);
    entry(3'd0, 32'h0000_0500, 32'h0000_0093, 0, "R5 priv->priv");
  endtask

  task automatic t_vectors_hi();
    entry(3'd2, 32'h0000_0600, 32'hFF00_001F, 1, "R7 susr->trap dtrap hi");
    entry(3'd3, 32'h0000_0700, 32'h0000_001B, 1, "R7 extn->intr hi");
    entry(3'd1, 32'h0000_0800, 32'h0000_0012, 0, "R6 intr->trap itrap lo");
  endtask

  task automatic t_entry_beats_write();
    @(negedge clk);
    reg_we = 1; reg_sel = 2'd1; reg_wdata = 32'hFFFF_FFFF;
    exc_valid = 1; exc_cause = 3'd0; cur_pc = 32'h0000_0900;
    cur_status = 32'h0000_0017; hivec_en = 0;
    @(negedge clk);
    reg_we = 0; exc_valid = 0;
    for (int f = 0; f < 3; f++) mb[2][f] = mb[5][f];
    mb[5][0] = mb[1][0]; mb[5][1] = 32'h0000_0900; mb[5][2] = 32'h0000_0017;
    m_pc = 32'h08; m_st = 32'h0000_0093;
    chk(link === 32'h0000_0900, "R12 entry priority", link, 32'h0000_0900);
    check_store("R12 entry priority store");
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 6; b++) for (int f = 0; f < 3; f++) mb[b][f] = 0;
    m_pc = 0; m_st = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_port();
    t_chain();
    t_same_mode();
    t_vectors_hi();
    bad_req(3'd5, 32'h0000_0012, "R11 bad cause");
    bad_req(3'd0, 32'h0000_0000, "R11 bad mode");
    t_entry_beats_write();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule